// File: doc/BRIEF.md
# Configuration-Space Base Address Register Bank

This block is a small configuration-register bank for a bus target. It holds three 32-bit base address registers and a read-only self-test byte, and it decodes incoming transaction addresses against the windows those registers describe. Window 0 maps a control/status region in memory space, window 1 maps the same control/status region in I/O space, and window 2 maps a flash region in memory space.

Software reaches the registers through a simple configuration port: a dword offset, four byte enables, a write strobe, write data and combinational read data. Each register has a writable mask that follows from its window size, a parameter that must be a power of two. Writing all ones and reading back therefore returns the size mask together with the fixed low bits. Software takes the two's complement of the masked value to find the size, then writes the base.

The decoder compares a memory address against the memory windows and an I/O address against the I/O window. For each address space it reports a one-hot hit vector and a window index. Each space is gated by its own enable input.

Top module: `cfgw_bank`

## Requirements
- R1: Dword offset 3 (byte 0x0F occupies bits 31:24) always reads zero, which reports that self-test is not supported. Writes there change nothing. Every dword offset that holds no base register also reads zero.
- R2: The base registers sit at dword offsets 4, 5 and 6 (byte offsets 0x10, 0x14 and 0x18), in that order: control/status memory window (index 0), control/status I/O window (index 1), flash memory window (index 2).
- R3: Bit 0 of each base register is read-only. It reads 0 for a memory window and 1 for the I/O window. Bit 1 of the I/O register always reads 0.
- R4: In a memory register, bits 2:1 read the placement parameter (00 anywhere in 32-bit space, 01 below 1 MB, 10 anywhere in 64-bit space) and bit 3 reads the prefetchable parameter. Writes do not change these bits. By default the flash window is prefetchable and both memory windows use placement 00.
- R5: Only the address bits at or above the window size are writable, and all bits below it read as zero apart from the fixed low bits. With the default sizes (4 KB, 32 B, 1 MB), writing all ones reads back 0xFFFFF000, 0xFFFFFFE1 and 0xFFF00008.
- R6: A write updates only the byte lanes whose enable is set, where enable bit n covers data bits 8n+7:8n. Within a lane, only the writable bits change.
- R7: After a synchronous active-low reset, every writable base bit is zero.
- R8: While the memory enable is high, a memory address hits memory window i when the address, masked by that window's writable mask, equals its programmed base. The hit vector is one-hot. When two memory windows both match, the lowest index wins. The index output gives the number of the winning window.
- R9: While the I/O enable is high, an I/O address is decoded in the same way against the I/O window only. Memory windows never report an I/O hit, and the I/O window never reports a memory hit.
- R10: When the memory enable is low, the memory hit vector is zero. When the I/O enable is low, the I/O hit vector is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword offset |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_addr (combinational) |
| mem_en | input | 1 | Memory-space decode enable |
| mem_addr | input | 32 | Memory transaction address |
| io_en | input | 1 | I/O-space decode enable |
| io_addr | input | 32 | I/O transaction address |
| mem_hit_vec | output | 3 | One-hot memory window hit |
| mem_win | output | 2 | Index of the hitting memory window |
| io_hit_vec | output | 3 | One-hot I/O window hit |
| io_win | output | 2 | Index of the hitting I/O window |

## Verification
The hardest case to reach is two memory windows that both claim one address, because software has to place a 4 KB control window inside the 1 MB flash window first. The stimulus sizes both windows, writes the same base into each, and then sends one address inside the small window and one inside the flash window only. It checks that the lower index wins the first address and the flash window wins the second. Byte-lane writes into a partly writable lane are also covered: a full 0xFF is written into the lane that holds the flash size boundary, and only its upper nibble may change.

// File: rtl/cfgw_pkg.sv
// Package: shared constants for the configuration base-register bank.
// Assumes a fixed count of three windows laid out on consecutive dwords.
package cfgw_pkg;
    localparam int unsigned NWIN      = 3;
    localparam int unsigned IDXW      = 2;
    localparam int unsigned DWAW      = 6;
    localparam int unsigned BAR_DW0   = 4;   // first base register dword
    localparam int unsigned SELFTEST_DW = 3; // dword holding self-test byte

    typedef logic [31:0] word_t;

    // Writable mask for a window of 2**log2 bytes.
    function automatic word_t size_mask(input int unsigned log2);
        return ~((32'd1 << log2) - 32'd1);
    endfunction
endpackage

// File: rtl/cfgw_base_reg.sv
// Module: one base address register.
// Holds the writable upper bits of a window base and presents the fixed
// low bits (space indicator, placement, prefetch) on reads.
// Assumes SIZE_LOG2 is at least 4 for memory windows and 2 for I/O windows, and below 32.
module cfgw_base_reg
    import cfgw_pkg::*;
#(
    parameter bit          IS_IO     = 1'b0,
    parameter int unsigned SIZE_LOG2 = 12,
    parameter logic [1:0]  PLACE     = 2'b00,
    parameter bit          PREFETCH  = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rd_value,
    output logic [31:0] base_q,
    output logic [31:0] mask
);
    localparam word_t WMASK = size_mask(SIZE_LOG2);
    localparam word_t FIXED = IS_IO ? 32'h0000_0001
                                    : {28'd0, PREFETCH, PLACE, 1'b0};

    // Parameter sanity: minimum window size per address space.
    initial begin
        assert (SIZE_LOG2 >= (IS_IO ? 2 : 4) && SIZE_LOG2 < 32)
            else $error("cfgw_base_reg: illegal window size");
    end

    // Per-lane update of writable bits; reset clears the base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_sel) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) begin
                    base_q[8*b +: 8] <= wdata[8*b +: 8] & WMASK[8*b +: 8];
                end
            end
        end
    end

    // Read value merges programmed base and hard-wired low bits.
    assign rd_value = base_q | FIXED;
    assign mask     = WMASK;

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(base_q)); // R6
    AST_LANE0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !be[0]) |=> base_q[7:0] == $past(base_q[7:0])); // R6
    AST_LANE3_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !be[3]) |=> base_q[31:24] == $past(base_q[31:24])); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> base_q == 32'd0); // R7
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (rd_value & ~WMASK) == FIXED); // R5
endmodule

// File: rtl/cfgw_decode.sv
// Module: address decoder for the window bank.
// Compares each address against the windows of its own space and returns a
// lowest-index-wins one-hot vector plus its index. Assumes bases are
// already masked to their writable bits.
module cfgw_decode
    import cfgw_pkg::*;
#(
    parameter int unsigned     N     = NWIN,
    parameter int unsigned     IW    = IDXW,
    parameter logic [N-1:0]    IS_IO = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mem_en,
    input  logic [31:0]         mem_addr,
    input  logic                io_en,
    input  logic [31:0]         io_addr,
    input  logic [N-1:0][31:0]  bases,
    input  logic [N-1:0][31:0]  masks,
    output logic [N-1:0]        mem_hit_vec,
    output logic [IW-1:0]       mem_win,
    output logic [N-1:0]        io_hit_vec,
    output logic [IW-1:0]       io_win
);
    logic [N-1:0] mem_raw, io_raw;

    // Per-window comparators, one set per address space.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        if (IS_IO[i]) begin : g_io
            assign io_raw[i]  = io_en && ((io_addr & masks[i]) == bases[i]);
            assign mem_raw[i] = 1'b0;
        end else begin : g_mem
            assign mem_raw[i] = mem_en && ((mem_addr & masks[i]) == bases[i]);
            assign io_raw[i]  = 1'b0;
        end
    end

    // Lowest set bit wins on overlap.
    assign mem_hit_vec = mem_raw & ~(mem_raw - N'(1));
    assign io_hit_vec  = io_raw  & ~(io_raw  - N'(1));

    // Encode winning windows to indices.
    always_comb begin
        mem_win = '0;
        io_win  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mem_hit_vec[i]) mem_win = IW'(i);
            if (io_hit_vec[i])  io_win  = IW'(i);
        end
    end

    AST_MEM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_hit_vec)); // R8
    AST_IO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(io_hit_vec)); // R9
    AST_SPACE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_hit_vec & IS_IO) == '0) && ((io_hit_vec & ~IS_IO) == '0)); // R9
    AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> mem_hit_vec == '0); // R10
    AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |-> io_hit_vec == '0); // R10
endmodule

// File: rtl/cfgw_bank.sv
// Module: top of the configuration base-register bank.
// Routes configuration writes to three base registers, muxes read data
// (self-test byte and unmapped dwords read zero) and decodes addresses.
// Assumes configuration reads are combinational on cfg_dw_addr.
module cfgw_bank
    import cfgw_pkg::*;
#(
    parameter int unsigned CSR_MEM_LOG2  = 12,
    parameter int unsigned CSR_IO_LOG2   = 5,
    parameter int unsigned FLASH_LOG2    = 20,
    parameter logic [1:0]  CSR_PLACE     = 2'b00,
    parameter bit          CSR_PREFETCH  = 1'b0,
    parameter logic [1:0]  FLASH_PLACE   = 2'b00,
    parameter bit          FLASH_PREFETCH = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        mem_en,
    input  logic [31:0] mem_addr,
    input  logic        io_en,
    input  logic [31:0] io_addr,
    output logic [2:0]  mem_hit_vec,
    output logic [1:0]  mem_win,
    output logic [2:0]  io_hit_vec,
    output logic [1:0]  io_win
);
    localparam logic [NWIN-1:0] WIN_IS_IO = 3'b010;
    localparam int unsigned WLOG2 [NWIN] = '{CSR_MEM_LOG2, CSR_IO_LOG2, FLASH_LOG2};
    localparam logic [1:0]  WPLACE [NWIN] = '{CSR_PLACE, 2'b00, FLASH_PLACE};
    localparam bit          WPF    [NWIN] = '{CSR_PREFETCH, 1'b0, FLASH_PREFETCH};

    logic [NWIN-1:0][31:0] rd_vals, bases, masks;
    logic [NWIN-1:0]       wr_sel;

    // One base register per window, variant chosen by parameters.
    for (genvar i = 0; i < NWIN; i++) begin : g_win
        assign wr_sel[i] = cfg_wr && (cfg_dw_addr == DWAW'(BAR_DW0 + i));
        cfgw_base_reg #(
            .IS_IO    (WIN_IS_IO[i]),
            .SIZE_LOG2(WLOG2[i]),
            .PLACE    (WPLACE[i]),
            .PREFETCH (WPF[i])
        ) reg_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_sel[i]),
            .be      (cfg_be),
            .wdata   (cfg_wdata),
            .rd_value(rd_vals[i]),
            .base_q  (bases[i]),
            .mask    (masks[i])
        );
    end

    // Read mux: base registers at their dwords, zero elsewhere.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (cfg_dw_addr == DWAW'(BAR_DW0 + i)) cfg_rdata = rd_vals[i];
        end
    end

    cfgw_decode #(
        .N    (NWIN),
        .IW   (IDXW),
        .IS_IO(WIN_IS_IO)
    ) dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_en     (mem_en),
        .mem_addr   (mem_addr),
        .io_en      (io_en),
        .io_addr    (io_addr),
        .bases      (bases),
        .masks      (masks),
        .mem_hit_vec(mem_hit_vec),
        .mem_win    (mem_win),
        .io_hit_vec (io_hit_vec),
        .io_win     (io_win)
    );

    AST_SELFTEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw_addr == DWAW'(SELFTEST_DW)) |-> cfg_rdata == 32'd0); // R1
    AST_IO_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw_addr == DWAW'(BAR_DW0 + 1)) |-> cfg_rdata[1:0] == 2'b01); // R3
    AST_MEM_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw_addr == DWAW'(BAR_DW0)) |-> cfg_rdata[0] == 1'b0); // R3
endmodule

// File: tb/cfgw_bank_tb.sv
// Directed bench for cfgw_bank: one task per scenario, each self-checking.
module cfgw_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_en = 1'b0, io_en = 1'b0;
    logic [31:0] mem_addr = '0, io_addr = '0;
    logic [2:0]  mem_hit_vec, io_hit_vec;
    logic [1:0]  mem_win, io_win;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    cfgw_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_en(mem_en), .mem_addr(mem_addr), .io_en(io_en), .io_addr(io_addr),
        .mem_hit_vec(mem_hit_vec), .mem_win(mem_win),
        .io_hit_vec(io_hit_vec), .io_win(io_win)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_dw_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_dw_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic probe_mem(input logic [31:0] a, output logic [31:0] v, output logic [31:0] w);
        @(negedge clk);
        mem_addr = a;
        #1 v = 32'(mem_hit_vec); w = 32'(mem_win);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        cfg_read(6'd4, d); chk("R7 bar0 reset", d, 32'h0000_0000);
        cfg_read(6'd5, d); chk("R7 bar1 reset", d, 32'h0000_0001);
        cfg_read(6'd6, d); chk("R7 bar2 reset", d, 32'h0000_0008);
    endtask

    task automatic t_selftest();
        logic [31:0] d;
        cfg_write(6'd3, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd3, d); chk("R1 selftest dword", d, 32'h0);
        cfg_write(6'd7, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd7, d); chk("R1 unmapped dword 7", d, 32'h0);
        cfg_read(6'd6, d); chk("R1 bar2 untouched by stray writes", d, 32'h0000_0008);
    endtask

    task automatic t_probe();
        logic [31:0] d;
        for (int i = 4; i < 7; i++) cfg_write(6'(i), 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd4, d); chk("R5 R2 csr mem size", d, 32'hFFFF_F000);
        cfg_read(6'd5, d); chk("R5 R3 csr io size", d, 32'hFFFF_FFE1);
        cfg_read(6'd6, d); chk("R5 R4 flash size", d, 32'hFFF0_0008);
    endtask

    task automatic t_fixed_bits();
        logic [31:0] d;
        cfg_write(6'd6, 4'hF, 32'h0000_000F);
        cfg_read(6'd6, d); chk("R4 fixed bits flash", d[3:0], 32'h8);
        cfg_write(6'd5, 4'hF, 32'h0000_0002);
        cfg_read(6'd5, d); chk("R3 io bit1 zero", d[1:0], 32'h1);
        cfg_write(6'd4, 4'hF, 32'h0000_0001);
        cfg_read(6'd4, d); chk("R3 mem bit0 zero", d, 32'h0);
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        cfg_write(6'd6, 4'hF, 32'h1230_0000);
        cfg_read(6'd6, d); chk("R6 full write", d, 32'h1230_0008);
        cfg_write(6'd6, 4'b1000, 32'hAB00_0000);
        cfg_read(6'd6, d); chk("R6 lane3 only", d, 32'hAB30_0008);
        cfg_write(6'd6, 4'b0100, 32'h00FF_0000);
        cfg_read(6'd6, d); chk("R6 lane2 partial mask", d, 32'hABF0_0008);
        cfg_write(6'd6, 4'b0000, 32'h0000_0000);
        cfg_read(6'd6, d); chk("R6 no lanes", d, 32'hABF0_0008);
    endtask

    task automatic t_mem_decode();
        logic [31:0] v, w;
        cfg_write(6'd4, 4'hF, 32'h8000_1000);
        cfg_write(6'd6, 4'hF, 32'h4000_0000);
        mem_en = 1'b1;
        probe_mem(32'h8000_1FFC, v, w); chk("R8 csr hit vec", v, 32'b001); chk("R8 csr idx", w, 0);
        probe_mem(32'h400F_FFFF, v, w); chk("R8 flash hit vec", v, 32'b100); chk("R8 flash idx", w, 2);
        probe_mem(32'h8000_2000, v, w); chk("R8 miss", v, 32'b000);
        io_addr = 32'h8000_1000; #1;
        chk("R9 mem addr not on io", 32'(io_hit_vec), 0);
    endtask

    task automatic t_io_decode();
        cfg_write(6'd5, 4'hF, 32'h0000_C040);
        io_en = 1'b1;
        @(negedge clk); io_addr = 32'h0000_C05F; #1;
        chk("R9 io hit vec", 32'(io_hit_vec), 32'b010);
        chk("R9 io idx", 32'(io_win), 1);
        @(negedge clk); io_addr = 32'h0000_C060; #1;
        chk("R9 io miss", 32'(io_hit_vec), 0);
        @(negedge clk); mem_addr = 32'h0000_C040; #1;
        chk("R9 io window not on mem", 32'(mem_hit_vec), 0);
    endtask

    task automatic t_enables();
        @(negedge clk);
        mem_addr = 32'h8000_1000; io_addr = 32'h0000_C040;
        mem_en = 1'b0; io_en = 1'b0; #1;
        chk("R10 mem disabled", 32'(mem_hit_vec), 0);
        chk("R10 io disabled", 32'(io_hit_vec), 0);
        @(negedge clk); io_en = 1'b1; #1;
        chk("R10 io reenabled", 32'(io_hit_vec), 32'b010);
    endtask

    task automatic t_overlap();
        logic [31:0] v, w;
        cfg_write(6'd4, 4'hF, 32'h4000_0000);
        cfg_write(6'd6, 4'hF, 32'h4000_0000);
        mem_en = 1'b1;
        probe_mem(32'h4000_0010, v, w); chk("R8 overlap lowest wins", v, 32'b001); chk("R8 overlap idx", w, 0);
        probe_mem(32'h4000_2000, v, w); chk("R8 flash only", v, 32'b100); chk("R8 flash only idx", w, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_selftest();
        t_probe();
        t_fixed_bits();
        t_bytes();
        t_mem_decode();
        t_io_decode();
        t_enables();
        t_overlap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule